// File: doc/BRIEF.md
# Two-Stage Cascaded Rate Multiplier

This block turns a steady stream of enabled clock cycles into a thinned pulse train. Two identical 4-bit counting stages each pass a programmable fraction of their slots, and the number of passed slots is set by a rate word. The stages can be chained in one of two ways, chosen by a mode input. In additive mode the pair acts as one 8-bit fraction. The first stage gives the coarse part, and the second stage fills the one slot in sixteen that the first stage always leaves empty. In product mode the second stage is stepped only by the first stage's pulses, so the output rate is the product of the two 4-bit fractions.

Typical uses are frequency synthesis, pacing of step generators and fractional clock division. The driver selects the mode and holds it while asserting the synchronous reset, then lets the enable run. Every enabled cycle is one slot, and the output is registered, so a slot's pulse appears one clock after that slot's edge.

Top module: `rate_mult2`

## Requirements
- R1: In additive mode (mode_i = 0), with coarse word M and fine word L, exactly 16*M + L output pulses occur in any 256 enabled cycles that start from reset (M=11, L=13 gives 189; M=15, L=15 gives 255; M=8, L=0 gives 128).
- R2: In product mode (mode_i = 1), exactly M*L pulses occur in 256 enabled cycles from reset (11 and 13 give 143; 15 and 15 give 225; 8 and 8 give 64).
- R3: In additive mode a fine-stage pulse can only occupy a slot in which the coarse counter is at 15, and the fine counter advances only in those slots. With M=0 and L=1 the single pulse lands on slot 127. With M=15 and L=15, slot 255 is the only empty slot.
- R4: A stage whose counter holds c and whose word bit 3 (weight 8) is set passes the slot when c is even. Bit 2 passes c mod 4 = 1, bit 1 passes c mod 8 = 3 and bit 0 passes c = 7. Count 15 never passes. Slots are numbered from 0 after reset, and slot k's pulse is seen one clock after the edge that processes it. With M=1 and L=0 in additive mode, slot 7 is the only pulse among slots 0..15. With M=4 the pulses fall on slots 1, 5, 9 and 13.
- R5: In additive mode the coarse pulse and the fine fill never coincide, so each pulse on the output stands for exactly one slot.
- R6: In product mode the second counter advances only on slots where the first stage pulses, and only the second stage drives the output. With M=8 and L=8, the pulses among slots 0..63 fall exactly on slots that are multiples of 4.
- R7: While ce_i is low, both counters hold and pulse_o is low one clock later. A run paused part-way still totals the R1 count.
- R8: rst_i is synchronous and has priority over ce_i. It clears both counters and holds pulse_o low, so the next run restarts at slot 0.
- R9: The mode is captured only while rst_i is high. Changing mode_i outside reset has no effect on the pulse train.
- R10: With both words zero, no pulse occurs in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high; also loads the mode |
| ce_i | input | 1 | Slot enable; one enabled cycle is one input slot |
| mode_i | input | 1 | 0 = additive cascade, 1 = product cascade |
| hi_word_i | input | 4 | Rate word of the first (coarse) stage |
| lo_word_i | input | 4 | Rate word of the second (fine) stage |
| pulse_o | output | 1 | Registered output pulse, one clock wide per passed slot |

## Verification
The bound checker watches the cascade rules on every cycle. It checks that in additive mode the fine stage only fills and only advances on the coarse stage's count-15 slot, and that the two sources never collide. It checks that in product mode the second counter stands still unless the first stage pulses, that a low enable freezes both counters and silences the output, that reset clears everything, and that the captured mode never changes outside reset. The exact pulse totals per 256 slots, the slot positions that the weight decode produces, the restart after a mid-run reset and the indifference to a mode change outside reset can only be shown by the bench's directed runs.

// File: rtl/rm_pkg.sv
package rm_pkg;

    typedef enum logic {
        CASC_ADD = 1'b0,
        CASC_MUL = 1'b1
    } casc_mode_e;

    typedef struct packed {
        casc_mode_e mode;
        logic       pulse;
    } top_state_t;

endpackage

// File: rtl/rm_rate_decode.sv
// Weighted slot decode: word bit j passes 2**j of every 2**W counter states,
// with disjoint state sets so the selected trains never overlap.
module rm_rate_decode #(
    parameter int W = 4
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] word_i,
    output logic         hit_o
);
    logic [W-1:0] bit_match;

    for (genvar j = 0; j < W; j++) begin : g_weight
        localparam int LOW = W - 1 - j;
        if (LOW == 0) begin : g_msb
            assign bit_match[j] = word_i[j] & ~cnt_i[0];
        end else begin : g_lsb
            assign bit_match[j] = word_i[j] & ~cnt_i[LOW] & (&cnt_i[LOW-1:0]);
        end
    end

    assign hit_o = |bit_match;
endmodule

// File: rtl/rm_stage.sv
// One counting stage: a W-bit binary counter with an advance strobe plus
// its weighted decode.
module rm_stage #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         adv_i,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] cnt_o,
    output logic         hit_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (adv_i) begin
            cnt_d = cnt_q + 1'b1;
        end
        if (rst_i) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        cnt_q <= cnt_d;
    end

    rm_rate_decode #(.W(W)) u_decode (
        .cnt_i  (cnt_q),
        .word_i (word_i),
        .hit_o  (hit_o)
    );

    assign cnt_o = cnt_q;
endmodule

// File: rtl/rm_link.sv
// Cascade routing between the two stages for the selected mode.
module rm_link
    import rm_pkg::*;
(
    input  logic       ce_i,
    input  casc_mode_e mode_i,
    input  logic       hi_hit_i,
    input  logic       hi_full_i,
    input  logic       lo_hit_i,
    output logic       hi_adv_o,
    output logic       lo_adv_o,
    output logic       up_pulse_o,
    output logic       lo_pulse_o,
    output logic       pulse_next_o
);
    always_comb begin
        hi_adv_o   = ce_i;
        up_pulse_o = ce_i & hi_hit_i;
        unique case (mode_i)
            CASC_ADD: begin
                lo_adv_o     = ce_i & hi_full_i;
                lo_pulse_o   = ce_i & hi_full_i & lo_hit_i;
                pulse_next_o = up_pulse_o | lo_pulse_o;
            end
            default: begin
                lo_adv_o     = up_pulse_o;
                lo_pulse_o   = up_pulse_o & lo_hit_i;
                pulse_next_o = lo_pulse_o;
            end
        endcase
    end
endmodule

// File: rtl/rate_mult2.sv
module rate_mult2
    import rm_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         ce_i,
    input  logic         mode_i,
    input  logic [W-1:0] hi_word_i,
    input  logic [W-1:0] lo_word_i,
    output logic         pulse_o
);
    localparam int          NSTAGE  = 2;
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] stage_word [NSTAGE];
    logic [W-1:0] stage_cnt  [NSTAGE];
    logic         stage_hit  [NSTAGE];
    logic         stage_adv  [NSTAGE];

    logic [W-1:0] up_cnt, lo_cnt;
    logic         hi_full;
    logic         up_pulse, lo_pulse, pulse_next;

    top_state_t st_d, st_q;
    casc_mode_e mode_q;

    assign stage_word[0] = hi_word_i;
    assign stage_word[1] = lo_word_i;

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        rm_stage #(.W(W)) u_stage (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .adv_i  (stage_adv[s]),
            .word_i (stage_word[s]),
            .cnt_o  (stage_cnt[s]),
            .hit_o  (stage_hit[s])
        );
    end

    assign up_cnt  = stage_cnt[0];
    assign lo_cnt  = stage_cnt[1];
    assign hi_full = (up_cnt == CNT_MAX);
    assign mode_q  = st_q.mode;

    rm_link u_link (
        .ce_i         (ce_i),
        .mode_i       (mode_q),
        .hi_hit_i     (stage_hit[0]),
        .hi_full_i    (hi_full),
        .lo_hit_i     (stage_hit[1]),
        .hi_adv_o     (stage_adv[0]),
        .lo_adv_o     (stage_adv[1]),
        .up_pulse_o   (up_pulse),
        .lo_pulse_o   (lo_pulse),
        .pulse_next_o (pulse_next)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = pulse_next;
        if (rst_i) begin
            st_d.mode  = casc_mode_e'(mode_i);
            st_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;
endmodule

// File: rtl/rate_mult2_chk.sv
module rate_mult2_chk #(
    parameter int W = 4
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic         ce_i,
    input logic         mode_q,
    input logic [W-1:0] up_cnt,
    input logic [W-1:0] lo_cnt,
    input logic         up_pulse,
    input logic         lo_pulse,
    input logic         pulse_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    AST_FILL_AT_FULL: assert property (@(posedge clk_i) disable iff (rst_i)
        (!mode_q && lo_pulse) |-> (up_cnt == CNT_MAX)); // R3

    AST_FINE_HOLD_ADD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!mode_q && up_cnt != CNT_MAX) |=> $stable(lo_cnt)); // R3

    AST_NO_COLLIDE: assert property (@(posedge clk_i) disable iff (rst_i)
        !mode_q |-> !(up_pulse && lo_pulse)); // R5

    AST_MUL_STEP_GATED: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_q && !up_pulse) |=> $stable(lo_cnt)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !ce_i |=> (!pulse_o && $stable(up_cnt) && $stable(lo_cnt))); // R7

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> (up_cnt == '0 && lo_cnt == '0 && !pulse_o)); // R8

    AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> $stable(mode_q)); // R9
endmodule

bind rate_mult2 rate_mult2_chk #(.W(W)) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .ce_i     (ce_i),
    .mode_q   (mode_q),
    .up_cnt   (up_cnt),
    .lo_cnt   (lo_cnt),
    .up_pulse (up_pulse),
    .lo_pulse (lo_pulse),
    .pulse_o  (pulse_o)
);

// File: tb/rate_mult2_bench.sv
`timescale 1ns/1ps
module rate_mult2_bench;
    logic       clk_i = 1'b0;
    logic       rst_i = 1'b1;
    logic       ce_i = 1'b0;
    logic       mode_i = 1'b0;
    logic [3:0] hi_word_i = '0;
    logic [3:0] lo_word_i = '0;
    logic       pulse_o;

    int n_chk = 0;
    int n_bad = 0;
    logic seen [0:511];
    int last_total;

    always #10 clk_i = ~clk_i;

    rate_mult2 u_rate_mult2 (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .ce_i      (ce_i),
        .mode_i    (mode_i),
        .hi_word_i (hi_word_i),
        .lo_word_i (lo_word_i),
        .pulse_o   (pulse_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic m, input logic [3:0] hw, input logic [3:0] lw);
        @(negedge clk_i);
        rst_i = 1'b1; ce_i = 1'b0; mode_i = m; hi_word_i = hw; lo_word_i = lw;
        repeat (2) @(negedge clk_i);
        rst_i = 1'b0;
    endtask

    // Runs n enabled slots starting at index base; seen[k] = pulse of slot k.
    task automatic run_slots(input int base, input int n);
        ce_i = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk_i);
            seen[base + k] = pulse_o;
            if (pulse_o) last_total++;
        end
        ce_i = 1'b0;
    endtask

    task automatic rate_run(input logic m, input logic [3:0] hw, input logic [3:0] lw,
                            input int exp, input string req);
        do_reset(m, hw, lw);
        last_total = 0;
        run_slots(0, 256);
        @(negedge clk_i);
        check(pulse_o == 1'b0, req, int'(pulse_o), 0);
        check(last_total == exp, req, last_total, exp);
    endtask

    task automatic t_reset_state();
        @(negedge clk_i);
        rst_i = 1'b1; ce_i = 1'b1; hi_word_i = 4'd15; lo_word_i = 4'd15;
        repeat (3) begin
            @(negedge clk_i);
            check(pulse_o == 1'b0, "R8 reset holds output low", int'(pulse_o), 0);
        end
        ce_i = 1'b0;
    endtask

    task automatic t_add_rates();
        rate_run(1'b0, 4'd11, 4'd13, 189, "R1 add 11,13");
        rate_run(1'b0, 4'd15, 4'd15, 255, "R1 add 15,15");
        rate_run(1'b0, 4'd8,  4'd0,  128, "R1 add 8,0");
        rate_run(1'b0, 4'd8,  4'd0,  128, "R5 single pulse per slot");
    endtask

    task automatic t_mul_rates();
        rate_run(1'b1, 4'd11, 4'd13, 143, "R2 mul 11,13");
        rate_run(1'b1, 4'd15, 4'd15, 225, "R2 mul 15,15");
        rate_run(1'b1, 4'd8,  4'd8,  64,  "R2 mul 8,8");
    endtask

    task automatic t_zero_words();
        rate_run(1'b0, 4'd0, 4'd0, 0, "R10 add zero");
        rate_run(1'b1, 4'd0, 4'd0, 0, "R10 mul zero");
    endtask

    task automatic t_upper_slots();
        int wrong;
        do_reset(1'b0, 4'd1, 4'd0);
        last_total = 0;
        run_slots(0, 16);
        wrong = 0;
        for (int k = 0; k < 16; k++) if (seen[k] != (k == 7)) wrong++;
        check(wrong == 0, "R4 weight1 slot 7", wrong, 0);
        do_reset(1'b0, 4'd4, 4'd0);
        last_total = 0;
        run_slots(0, 16);
        wrong = 0;
        for (int k = 0; k < 16; k++) if (seen[k] != (k % 4 == 1)) wrong++;
        check(wrong == 0, "R4 weight4 slots 1,5,9,13", wrong, 0);
    endtask

    task automatic t_fill_slots();
        int wrong;
        do_reset(1'b0, 4'd0, 4'd1);
        last_total = 0;
        run_slots(0, 256);
        wrong = 0;
        for (int k = 0; k < 256; k++) if (seen[k] != (k == 127)) wrong++;
        check(wrong == 0, "R3 fill lands on slot 127", wrong, 0);
        do_reset(1'b0, 4'd15, 4'd15);
        last_total = 0;
        run_slots(0, 256);
        check(seen[255] == 1'b0, "R3 slot 255 empty", int'(seen[255]), 0);
        check(seen[15] == 1'b1, "R3 slot 15 filled", int'(seen[15]), 1);
    endtask

    task automatic t_mul_pattern();
        int wrong;
        do_reset(1'b1, 4'd8, 4'd8);
        last_total = 0;
        run_slots(0, 64);
        wrong = 0;
        for (int k = 0; k < 64; k++) if (seen[k] != (k % 4 == 0)) wrong++;
        check(wrong == 0, "R6 mul slots multiple of 4", wrong, 0);
    endtask

    task automatic t_pause();
        int noisy;
        do_reset(1'b0, 4'd11, 4'd13);
        last_total = 0;
        run_slots(0, 100);
        noisy = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk_i);
            if (pulse_o) noisy++;
        end
        check(noisy == 0, "R7 no pulse while disabled", noisy, 0);
        run_slots(100, 156);
        @(negedge clk_i);
        check(last_total == 189, "R7 paused run total", last_total, 189);
    endtask

    task automatic t_reset_restart();
        int wrong;
        do_reset(1'b0, 4'd1, 4'd0);
        last_total = 0;
        run_slots(0, 5);
        do_reset(1'b0, 4'd1, 4'd0);
        run_slots(0, 16);
        wrong = 0;
        for (int k = 0; k < 16; k++) if (seen[k] != (k == 7)) wrong++;
        check(wrong == 0, "R8 restart from slot 0", wrong, 0);
    endtask

    task automatic t_mode_latch();
        do_reset(1'b0, 4'd11, 4'd13);
        @(negedge clk_i);
        mode_i = 1'b1;
        last_total = 0;
        run_slots(0, 256);
        @(negedge clk_i);
        check(last_total == 189, "R9 mode change without reset ignored", last_total, 189);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #4000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        t_reset_state();
        t_add_rates();
        t_mul_rates();
        t_zero_words();
        t_upper_slots();
        t_fill_slots();
        t_mul_pattern();
        t_pause();
        t_reset_restart();
        t_mode_latch();
        finish_run();
    end
endmodule